// File: doc/BRIEF.md
# Serial Clock Freeze Controller

This block lets a host stop and restart twelve clock outputs one by one, using only two wires: a slow serial clock and a data line. The host sends a frame that opens with a low start bit and carries one enable bit per output. The new enable pattern is stored only when the frame is complete. It is then passed into each output's own clock domain, where a gate stops or restarts that output without cutting a pulse short.

A bit value of 0 stops the matching output, and the output is held low. A bit value of 1 lets the output run. While no frame is in progress, the receiver waits for a low bit and ignores high bits. The bit that follows a complete frame does two things: it applies the stored pattern, and if it is low it also starts the next frame. A stop takes effect at the output's next falling edge. A restart takes effect so that the output's next rising edge is the first edge passed through. Every pulse that leaves the block is therefore a full-width pulse of its source clock.

Top module: `clkstop_ctl`

## Requirements
- R1: After reset every enable bit is 1, and each `clk_out[k]` follows `clk_in[k]`.
- R2: Every bit is sampled on a rising edge of `ser_clk`. A frame is a 0 start bit followed by 12 enable bits. The first enable bit received controls output 0, and the last one controls output 11.
- R3: An applied enable bit of 0 holds its output low. An applied enable bit of 1 lets its output follow its source clock.
- R4: The received bits change no output until the rising edge of `ser_clk` that follows the 12th enable bit. That edge, and no other, applies the new pattern.
- R5: On the apply edge, a data value of 0 applies the pattern and also counts as the start bit of the next frame.
- R6: While the receiver is waiting for a start bit, bits of value 1 are ignored and change nothing.
- R7: A stopped output goes low only at a falling edge of its source clock, so no high pulse is ever shortened.
- R8: A restarted output goes high only at a rising edge of its source clock, so every high pulse lasts a full source half-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data: start bit followed by enable bits |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| clk_in | input | 12 | Running source clocks, one per output |
| clk_out | output | 12 | Gated copies of the source clocks |

## Verification
The two receiver functions that can land on the same `ser_clk` edge are the apply of a finished pattern and the detection of the next frame's start bit. The bench provokes this by sending two frames back to back, with a 0 in the slot right after the 12th bit of the first frame. It then checks that the second frame's pattern appears on the outputs, which can only happen if that 0 served both as the apply edge and as the start bit. In the gate domain, a stop or restart can arrive while a source clock is high. For that case a pulse-width monitor on every output judges that the change waits for the next proper edge.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_LOAD = 2'd1,
    RX_FULL = 2'd2
  } rx_state_e;

  // Index of the last enable bit in a frame of n bits.
  function automatic int unsigned last_bit_index(input int unsigned n);
    return n - 1;
  endfunction

  // True once the bit at position idx is the final one of the frame.
  function automatic logic is_last_bit(input int unsigned idx, input int unsigned n);
    return idx == last_bit_index(n);
  endfunction
endpackage

// File: rtl/clkstop_rx.sv
module clkstop_rx
  import clkstop_pkg::*;
#(
  parameter int unsigned N_OUT = 12
) (
  input  logic             ser_clk,
  input  logic             rst_n,
  input  logic             ser_dat,
  output logic [N_OUT-1:0] mask_q,
  output logic             hunting,
  output logic             frame_full
);
  localparam int unsigned CW = (N_OUT > 1) ? $clog2(N_OUT) : 1;

  rx_state_e        state_q;
  logic [CW-1:0]    cnt_q;
  logic [N_OUT-1:0] shreg_q;

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      shreg_q <= '1;
      mask_q  <= '1;
    end else begin
      unique case (state_q)
        RX_HUNT: begin
          if (!ser_dat) begin
            state_q <= RX_LOAD;
            cnt_q   <= '0;
          end
        end
        RX_LOAD: begin
          shreg_q[cnt_q] <= ser_dat;
          if (is_last_bit(int'(cnt_q), N_OUT)) state_q <= RX_FULL;
          else                                 cnt_q   <= cnt_q + 1'b1;
        end
        RX_FULL: begin
          mask_q  <= shreg_q;
          cnt_q   <= '0;
          state_q <= ser_dat ? RX_HUNT : RX_LOAD;
        end
        default: state_q <= RX_HUNT;
      endcase
    end
  end

  assign hunting    = (state_q == RX_HUNT);
  assign frame_full = (state_q == RX_FULL);
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic run_req,
  output logic gate_en,
  output logic clk_out
);
  logic [SYNC_DEPTH-1:0] sync_q;

  generate
    if (SYNC_DEPTH == 1) begin : g_one
      always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= run_req;
      end
    end else begin : g_many
      always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_DEPTH-2:0], run_req};
      end
    end
  endgenerate

  // Enable changes only while the source clock is low.
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) gate_en <= 1'b1;
    else        gate_en <= sync_q[SYNC_DEPTH-1];
  end

  assign clk_out = clk_in & gate_en;
endmodule

// File: rtl/clkstop_ctl.sv
module clkstop_ctl #(
  parameter int unsigned N_OUT      = 12,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] clk_in,
  output logic [N_OUT-1:0] clk_out
);
  logic [N_OUT-1:0] mask_q;
  logic [N_OUT-1:0] gate_en;
  logic             hunting;
  logic             frame_full;

  clkstop_rx #(.N_OUT(N_OUT)) u_rx (
    .ser_clk   (ser_clk),
    .rst_n     (rst_n),
    .ser_dat   (ser_dat),
    .mask_q    (mask_q),
    .hunting   (hunting),
    .frame_full(frame_full)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_gate
    clkstop_gate #(.SYNC_DEPTH(SYNC_DEPTH)) u_gate (
      .clk_in (clk_in[g]),
      .rst_n  (rst_n),
      .run_req(mask_q[g]),
      .gate_en(gate_en[g]),
      .clk_out(clk_out[g])
    );
  end
endmodule

// File: rtl/clkstop_ctl_chk.sv
module clkstop_ctl_chk #(
  parameter int unsigned N_OUT = 12
) (
  input logic             ser_clk,
  input logic             rst_n,
  input logic             ser_dat,
  input logic             hunting,
  input logic             frame_full,
  input logic [N_OUT-1:0] mask_q,
  input logic [N_OUT-1:0] clk_in,
  input logic [N_OUT-1:0] gate_en
);
  // R4: the stored pattern moves only on the apply edge
  p_mask_hold_r4: assert property (@(posedge ser_clk) disable iff (!rst_n)
    !frame_full |=> $stable(mask_q));

  // R4: a full frame is applied on exactly one edge
  p_full_once_r4: assert property (@(posedge ser_clk) disable iff (!rst_n)
    frame_full |=> !frame_full);

  // R6: ones while hunting keep the receiver hunting
  p_hunt_ones_r6: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (hunting && ser_dat) |=> hunting);

  // R5: a zero on the apply edge opens the next frame
  p_chain_start_r5: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (frame_full && !ser_dat) |=> (!hunting && !frame_full));

  // R7, R8: gate enables move only while their source clock is low
  for (genvar g = 0; g < N_OUT; g++) begin : g_en
    always @(gate_en[g]) begin
      if (rst_n) begin
        p_gate_low_r7: assert (clk_in[g] == 1'b0)
          else $error("gate enable %0d moved while source high", g);
      end
    end
  end
endmodule

bind clkstop_ctl clkstop_ctl_chk #(.N_OUT(N_OUT)) u_chk (
  .ser_clk   (ser_clk),
  .rst_n     (rst_n),
  .ser_dat   (ser_dat),
  .hunting   (hunting),
  .frame_full(frame_full),
  .mask_q    (mask_q),
  .clk_in    (clk_in),
  .gate_en   (gate_en)
);

// File: tb/clkstop_ctl_tb.sv
`timescale 1ns/1ps
module clkstop_ctl_tb;
  localparam int N = 12;

  logic         ser_clk = 1'b0;
  logic         ser_dat = 1'b1;
  logic         rst_n   = 1'b1;
  wire  [N-1:0] clk_in;
  wire  [N-1:0] clk_out;
  wire  [N-1:0] runt_vec;

  int checks = 0;
  int fails  = 0;

  clkstop_ctl u_dut (
    .ser_clk(ser_clk),
    .ser_dat(ser_dat),
    .rst_n  (rst_n),
    .clk_in (clk_in),
    .clk_out(clk_out)
  );

  // Source clocks with distinct half periods, plus a pulse-width monitor per output
  for (genvar g = 0; g < N; g++) begin : g_src
    logic    c = 1'b0;
    logic    bad = 1'b0;
    realtime t_rise = -1.0;
    initial forever #(3 + g) c = ~c;
    assign clk_in[g] = c;
    always @(posedge clk_out[g]) t_rise = $realtime;
    always @(negedge clk_out[g])
      if (t_rise >= 200.0 && ($realtime - t_rise) != real'(3 + g)) bad = 1'b1;
    assign runt_vec[g] = bad;
  end

  // One serial bit on a 50 MHz bit clock
  task automatic send_bit(input logic b);
    ser_dat = b;
    #5 ser_clk = 1'b1;
    #10 ser_clk = 1'b0;
    #5;
  endtask

  // Start bit then enable bits, first bit controls output 0 (R2)
  task automatic send_frame(input logic [N-1:0] m);
    send_bit(1'b0);
    for (int k = 0; k < N; k++) send_bit(m[k]);
  endtask

  // Bench model: output k follows its source only when its bit is 1
  function automatic logic exp_out(input logic [N-1:0] m, input int k, input logic src);
    return m[k] ? src : 1'b0;
  endfunction

  task automatic check_out(input logic [N-1:0] m, input string tag);
    logic [N-1:0] err;
    int           hi_cnt [N];
    err = '0;
    for (int k = 0; k < N; k++) hi_cnt[k] = 0;
    #400.5;
    for (int s = 0; s < 200; s++) begin
      for (int k = 0; k < N; k++) begin
        if (clk_out[k] !== exp_out(m, k, clk_in[k])) err[k] = 1'b1;
        if (clk_out[k]) hi_cnt[k]++;
      end
      #1;
    end
    for (int k = 0; k < N; k++) begin
      checks++;
      if (err[k]) begin
        fails++;
        $display("FAIL %s out%0d: actual high samples %0d, expected enable %b", tag, k, hi_cnt[k], m[k]);
      end
    end
    #0.5;
  endtask

  logic [N-1:0] cur;

  initial begin
    void'($urandom(32'h5eed_c10c));
    #1 rst_n = 1'b0;
    #99 rst_n = 1'b1;
    #20;

    // R1: reset state, all outputs run
    check_out('1, "R1");

    // R4: a full frame without its apply edge changes nothing
    send_frame('0);
    check_out('1, "R4");
    // R3: apply edge, then every output is held low
    send_bit(1'b1);
    check_out('0, "R3");

    // R2: bit order, walking patterns
    send_frame(12'h001); send_bit(1'b1);
    check_out(12'h001, "R2");
    send_frame(12'h800); send_bit(1'b1);
    check_out(12'h800, "R2");

    // R6: idle ones are ignored, then a frame lands normally
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    check_out(12'h800, "R6");
    send_frame(12'hA5C); send_bit(1'b1);
    check_out(12'hA5C, "R6");

    // R5: apply edge doubles as start of the next frame
    send_frame(12'h3F0);
    send_bit(1'b0);
    for (int k = 0; k < N; k++) send_bit(cur[k] ^ 1'b0 | (k % 3 == 0));
    send_bit(1'b1);
    cur = '0;
    for (int k = 0; k < N; k++) cur[k] = (k % 3 == 0);
    check_out(cur, "R5");

    // R3, R6: random patterns with random idle gaps
    for (int r = 0; r < 6; r++) begin
      cur = N'($urandom);
      for (int i = 0; i < int'($urandom_range(0, 3)); i++) send_bit(1'b1);
      send_frame(cur);
      send_bit(1'b1);
      check_out(cur, "R3");
    end

    // Restart everything
    send_frame('1); send_bit(1'b1);
    check_out('1, "R8");

    // R7, R8: no shortened or misplaced high pulse on any output
    for (int k = 0; k < N; k++) begin
      checks++;
      if (runt_vec[k]) begin
        fails++;
        $display("FAIL R7/R8 out%0d: actual runt seen 1, expected 0", k);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    cur = '0;
    #1ms;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule